// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the cache controller for one processor on a shared bus that several caching masters use. It holds a small direct-mapped array of one-word lines. Each line carries a tag, a data word and one of four coherence states: Invalid, Valid (clean, possibly shared), Reserved (clean, only copy) and Dirty (modified, only copy). The processor side issues single-word reads and writes. On the bus side the controller is a master that issues fills, write-throughs and write-backs, one transaction at a time. It also watches the transactions of the other masters and updates its own line states from them.

Ownership is gained without a read-for-ownership. The first write to a Valid line is written through to memory. Other caches see that write and drop their copies, and the line here becomes Reserved. Later writes stay local and make the line Dirty. When another master reads a line held Dirty, the controller raises a hold signal that stalls that read. It writes the line back, drops the hold and lets the stalled read continue. A write miss runs as a fill followed by a write-through. A miss whose victim line is Dirty writes that victim back before the fill starts.

Top module: `wo_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, bus_req, cpu_done and snp_hold are low, and the first access to any address is a miss.
- R2: A read hit returns the stored word with cpu_done one cycle after the request is taken, issues no bus transaction and leaves the line state unchanged.
- R3: A read miss issues a bus read (bus_cmd 1) for the requested address, returns bus_rdata on cpu_done the cycle after the read completes, and leaves the line Valid.
- R4: A write hit to a Reserved or Dirty line updates only the cache, issues no bus transaction and leaves the line Dirty.
- R5: A write hit to a Valid line issues one write-through (bus_cmd 2) carrying the address and new word, signals cpu_done the cycle after it completes, and leaves the line Reserved.
- R6: A write miss issues a bus read of the address, then a write-through of the new word, and leaves the line Reserved.
- R7: A miss whose victim line (same index, address bits [IDX_W-1:0]) is Dirty first writes the victim back (bus_cmd 3, victim address and word) and then issues the fill. A clean victim is dropped without a write-back.
- R8: A snooped read (snp_cmd 1) of a line held Dirty raises snp_hold, causes a write-back of that line, and drops snp_hold only after that write-back completes. The line is then Valid.
- R9: A snooped read of a line held Reserved moves it to Valid, without a hold.
- R10: A snooped write-through (snp_cmd 2) to a line held here makes that line Invalid.
- R11: A processor request is not taken in any cycle in which snp_valid is high, so snoop updates win over local accesses.
- R12: While bus_req is high, bus_cmd is non-zero, and bus_cmd and bus_addr stay stable until the transaction completes (bus_req, bus_gnt and bus_ack all high), unless a snoop hold preempts it.
- R13: cpu_done is a one-cycle pulse and only follows a cycle in which cpu_req was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| bus_req | output | 1 | Master request, high for the whole transaction |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd | output | 2 | 0 none, 1 read, 2 write-through, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write word for write-through and write-back |
| bus_ack | input | 1 | Memory completes the granted transaction |
| bus_rdata | input | DW | Memory read word, valid with bus_ack |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | AW | Snooped address |
| snp_hold | output | 1 | Stalls the snooped read until this cache writes back |

## Verification
The assertions take four things for granted about the environment. bus_gnt and bus_ack come only while bus_req is high. A snooped transaction stays on snp_valid, unchanged, for as long as snp_hold is high. No other master's transaction is snooped while this master is granted, except for its own write-back under a hold. cpu_req stays high until cpu_done and drops on the following cycle. The bench keeps to these rules: it drives snoops only when the processor side is idle (apart from the one deliberate collision that checks priority), it holds each snoop until the hold clears, it grants only a pending request after a short rotating delay, and it drops the request as soon as it sees the completion pulse.

// File: rtl/wo_pkg.sv
package wo_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RES = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WTHRU = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_EVICT = 3'd1,
    FS_FILL  = 3'd2,
    FS_WTHRU = 3'd3,
    FS_SNPWB = 3'd4
  } ctl_st_e;

endpackage

// File: rtl/wo_line_array.sv
module wo_line_array
  import wo_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup port (processor side)
  input  logic [IDX_W-1:0] la_idx,
  output logic [TAG_W-1:0] la_tag,
  output logic [DW-1:0]    la_data,
  output line_st_e         la_st,
  // lookup port (snoop side)
  input  logic [IDX_W-1:0] sp_idx,
  output logic [TAG_W-1:0] sp_tag,
  output logic [DW-1:0]    sp_data,
  output line_st_e         sp_st,
  // controller write port
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_tag_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_data_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_st_en,
  input  line_st_e         wr_st,
  // snoop state port, wins over the controller port
  input  logic             su_en,
  input  logic [IDX_W-1:0] su_idx,
  input  line_st_e         su_st
);

  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];
  line_st_e         st_q   [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    logic tag_ce, data_ce, st_ce_ctl, st_ce_snp;
    assign tag_ce    = wr_tag_en  && (wr_idx == MY_IDX);
    assign data_ce   = wr_data_en && (wr_idx == MY_IDX);
    assign st_ce_ctl = wr_st_en   && (wr_idx == MY_IDX);
    assign st_ce_snp = su_en      && (su_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (tag_ce) tag_q[g] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (data_ce) data_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_q[g] <= LS_INV;
      else if (st_ce_snp) st_q[g] <= su_st;
      else if (st_ce_ctl) st_q[g] <= wr_st;
    end
  end

  assign la_tag  = tag_q[la_idx];
  assign la_data = data_q[la_idx];
  assign la_st   = st_q[la_idx];
  assign sp_tag  = tag_q[sp_idx];
  assign sp_data = data_q[sp_idx];
  assign sp_st   = st_q[sp_idx];

endmodule

// File: rtl/wo_snoop.sv
module wo_snoop
  import wo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  localparam int TAG_W = AW - IDX_W
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [AW-1:0]    snp_addr,
  input  logic [TAG_W-1:0] ln_tag,
  input  line_st_e         ln_st,
  output logic [IDX_W-1:0] sn_idx,
  output logic             hold,
  output logic             upd_en,
  output line_st_e         upd_st
);

  logic hit;

  assign sn_idx = snp_addr[IDX_W-1:0];
  assign hit    = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_addr[AW-1:IDX_W]);

  always_comb begin
    hold   = 1'b0;
    upd_en = 1'b0;
    upd_st = LS_INV;
    if (hit) begin
      unique case (snp_cmd)
        BC_READ: begin
          if (ln_st == LS_DRT) begin
            hold = 1'b1;          // stall until our write-back lands
          end else if (ln_st == LS_RES) begin
            upd_en = 1'b1;
            upd_st = LS_VAL;
          end
        end
        BC_WTHRU: begin
          upd_en = 1'b1;
          upd_st = LS_INV;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wo_ctrl.sv
module wo_ctrl
  import wo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int IDX_W = 2,
  localparam int TAG_W = AW - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_done,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             snp_valid,
  input  logic [AW-1:0]    snp_addr,
  input  logic             snp_hold,
  input  logic [DW-1:0]    sp_data,
  output logic [IDX_W-1:0] la_idx,
  input  logic [TAG_W-1:0] la_tag,
  input  logic [DW-1:0]    la_data,
  input  line_st_e         la_st,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_tag_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic             wr_data_en,
  output logic [DW-1:0]    wr_data,
  output logic             wr_st_en,
  output line_st_e         wr_st,
  output logic             bus_req,
  input  logic             bus_gnt,
  input  logic             bus_ack,
  output bus_cmd_e         bus_cmd,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata
);

  ctl_st_e          st_q, st_d, ret_q, ret_d;
  logic             done_q, done_d;
  logic             we_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdat_q, rdat_q, rd_d;
  logic             req_ld, rd_ld;
  logic             cpu_hit, bus_fire;
  logic [IDX_W-1:0] req_idx;

  assign req_idx  = addr_q[IDX_W-1:0];
  assign la_idx   = (st_q == FS_IDLE) ? cpu_addr[IDX_W-1:0] : req_idx;
  assign cpu_hit  = (la_st != LS_INV) && (la_tag == cpu_addr[AW-1:IDX_W]);
  assign bus_req  = (st_q != FS_IDLE);
  assign bus_fire = bus_req && bus_gnt && bus_ack;

  // next-state and array-update decode
  always_comb begin
    st_d       = st_q;
    ret_d      = ret_q;
    done_d     = 1'b0;
    req_ld     = 1'b0;
    rd_ld      = 1'b0;
    rd_d       = la_data;
    wr_idx     = la_idx;
    wr_tag_en  = 1'b0;
    wr_tag     = addr_q[AW-1:IDX_W];
    wr_data_en = 1'b0;
    wr_data    = wdat_q;
    wr_st_en   = 1'b0;
    wr_st      = LS_INV;
    unique case (st_q)
      FS_IDLE: begin
        if (snp_hold) begin
          ret_d = FS_IDLE;
          st_d  = FS_SNPWB;
        end else if (cpu_req && !snp_valid) begin
          req_ld = 1'b1;
          if (cpu_hit && !cpu_we) begin
            done_d = 1'b1;
            rd_ld  = 1'b1;
          end else if (cpu_hit && la_st == LS_VAL) begin
            st_d = FS_WTHRU;
          end else if (cpu_hit) begin
            wr_data_en = 1'b1;
            wr_data    = cpu_wdata;
            wr_st_en   = 1'b1;
            wr_st      = LS_DRT;
            done_d     = 1'b1;
          end else begin
            st_d = (la_st == LS_DRT) ? FS_EVICT : FS_FILL;
          end
        end
      end
      FS_EVICT: begin
        if (bus_fire) begin
          wr_st_en = 1'b1;
          wr_st    = LS_INV;
          st_d     = FS_FILL;
        end else if (snp_hold) begin
          ret_d = FS_EVICT;
          st_d  = FS_SNPWB;
        end
      end
      FS_FILL: begin
        if (bus_fire) begin
          wr_tag_en  = 1'b1;
          wr_data_en = 1'b1;
          wr_data    = bus_rdata;
          wr_st_en   = 1'b1;
          wr_st      = LS_VAL;
          if (we_q) begin
            st_d = FS_WTHRU;
          end else begin
            done_d = 1'b1;
            rd_ld  = 1'b1;
            rd_d   = bus_rdata;
            st_d   = FS_IDLE;
          end
        end else if (snp_hold) begin
          ret_d = FS_FILL;
          st_d  = FS_SNPWB;
        end
      end
      FS_WTHRU: begin
        if (bus_fire) begin
          wr_data_en = 1'b1;
          wr_st_en   = 1'b1;
          wr_st      = LS_RES;
          done_d     = 1'b1;
          st_d       = FS_IDLE;
        end else if (snp_hold) begin
          ret_d = FS_WTHRU;
          st_d  = FS_SNPWB;
        end
      end
      FS_SNPWB: begin
        if (bus_fire) begin
          wr_idx   = snp_addr[IDX_W-1:0];
          wr_st_en = 1'b1;
          wr_st    = LS_VAL;
          st_d     = ret_q;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  // bus drive per state
  always_comb begin
    bus_cmd   = BC_NONE;
    bus_addr  = addr_q;
    bus_wdata = wdat_q;
    unique case (st_q)
      FS_EVICT: begin
        bus_cmd   = BC_WBACK;
        bus_addr  = {la_tag, req_idx};
        bus_wdata = la_data;
      end
      FS_FILL:  bus_cmd = BC_READ;
      FS_WTHRU: bus_cmd = BC_WTHRU;
      FS_SNPWB: begin
        bus_cmd   = BC_WBACK;
        bus_addr  = snp_addr;
        bus_wdata = sp_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      ret_q  <= FS_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) begin
      we_q   <= cpu_we;
      addr_q <= cpu_addr;
      wdat_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_ld) rdat_q <= rd_d;
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdat_q;

endmodule

// File: rtl/wo_cache_ctrl.sv
module wo_cache_ctrl
  import wo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hold
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [IDX_W-1:0] la_idx, sp_idx, wr_idx;
  logic [TAG_W-1:0] la_tag, sp_tag, wr_tag;
  logic [DW-1:0]    la_data, sp_data, wr_data;
  line_st_e         la_st, sp_st, wr_st, su_st;
  logic             wr_tag_en, wr_data_en, wr_st_en, su_en;
  bus_cmd_e         bus_cmd_e_w;

  wo_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) i_array (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .la_idx     (la_idx),
    .la_tag     (la_tag),
    .la_data    (la_data),
    .la_st      (la_st),
    .sp_idx     (sp_idx),
    .sp_tag     (sp_tag),
    .sp_data    (sp_data),
    .sp_st      (sp_st),
    .wr_idx     (wr_idx),
    .wr_tag_en  (wr_tag_en),
    .wr_tag     (wr_tag),
    .wr_data_en (wr_data_en),
    .wr_data    (wr_data),
    .wr_st_en   (wr_st_en),
    .wr_st      (wr_st),
    .su_en      (su_en),
    .su_idx     (sp_idx),
    .su_st      (su_st)
  );

  wo_snoop #(.AW(AW), .IDX_W(IDX_W)) i_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_addr  (snp_addr),
    .ln_tag    (sp_tag),
    .ln_st     (sp_st),
    .sn_idx    (sp_idx),
    .hold      (snp_hold),
    .upd_en    (su_en),
    .upd_st    (su_st)
  );

  wo_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_done   (cpu_done),
    .cpu_rdata  (cpu_rdata),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .snp_hold   (snp_hold),
    .sp_data    (sp_data),
    .la_idx     (la_idx),
    .la_tag     (la_tag),
    .la_data    (la_data),
    .la_st      (la_st),
    .wr_idx     (wr_idx),
    .wr_tag_en  (wr_tag_en),
    .wr_tag     (wr_tag),
    .wr_data_en (wr_data_en),
    .wr_data    (wr_data),
    .wr_st_en   (wr_st_en),
    .wr_st      (wr_st),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_ack    (bus_ack),
    .bus_cmd    (bus_cmd_e_w),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
  );

  assign bus_cmd = bus_cmd_e_w;

endmodule

// File: rtl/wo_cache_chk.sv
module wo_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_ack,
  input logic [1:0] bus_cmd,
  input logic [7:0] bus_addr_lo,
  input logic       snp_valid,
  input logic       snp_hold
);

  logic bus_fire;
  assign bus_fire = bus_req && bus_gnt && bus_ack;

  // R12
  bus_cmd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd != 2'd0));

  // R12
  bus_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_fire && !snp_hold) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr_lo)));

  // R3
  fill_then_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_cmd == 2'd1) |=> (cpu_done || (bus_req && bus_cmd == 2'd2)));

  // R5
  wthru_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_cmd == 2'd2) |=> cpu_done);

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snp_hold) |-> $past(bus_fire && bus_cmd == 2'd3));

  // R11
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !bus_req) |=> !cpu_done);

  // R13
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(cpu_req));

endmodule

bind wo_cache_ctrl wo_cache_chk i_wo_cache_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_done    (cpu_done),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_ack     (bus_ack),
  .bus_cmd     (bus_cmd),
  .bus_addr_lo (8'(bus_addr)),
  .snp_valid   (snp_valid),
  .snp_hold    (snp_hold)
);

// File: tb/test_wo_cache_ctrl.sv
`timescale 1ns/1ps
module test_wo_cache_ctrl;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt, bus_ack;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_hold;

  wo_cache_ctrl #(.AW(AW), .DW(DW), .LINES(4)) i_wo_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_hold(snp_hold)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  typedef struct packed {
    logic          is_bus;
    logic          cmp_data;
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [31:0]   tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] mem [1 << AW];
  int            n_chk = 0;
  int            n_err = 0;
  int            wait_cnt = 0;
  int            lat = 1;
  logic [1:0]    seen_cmd;
  logic [AW-1:0] seen_addr;

  task automatic chk(input logic ok, input logic [31:0] tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [1:0] cmd, input logic [AW-1:0] addr,
                         input logic [DW-1:0] data, input logic [31:0] tag);
    sb_q.push_back('{is_bus: 1'b1, cmp_data: (cmd != 2'd1), cmd: cmd,
                     addr: addr, data: data, tag: tag});
  endtask

  task automatic exp_cpu(input logic cmp, input logic [DW-1:0] data, input logic [31:0] tag);
    sb_q.push_back('{is_bus: 1'b0, cmp_data: cmp, cmd: 2'd0,
                     addr: '0, data: data, tag: tag});
  endtask

  // monitor: bus responder plus scoreboard, all on the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (bus_gnt) begin
        bus_gnt  = 1'b0;
        bus_ack  = 1'b0;
        wait_cnt = 0;
      end else if (bus_req) begin
        if (wait_cnt == 0) begin
          seen_cmd  = bus_cmd;
          seen_addr = bus_addr;
        end
        wait_cnt++;
        if (wait_cnt > lat) begin
          // R12: request held unchanged while waiting for the grant
          chk(bus_cmd == seen_cmd && bus_addr == seen_addr, "R12",
              {22'd0, bus_cmd, bus_addr}, {22'd0, seen_cmd, seen_addr});
          if (sb_q.size() == 0) begin
            chk(1'b0, "bus", {22'd0, bus_cmd, bus_addr}, 32'hFFFF_FFFF);
          end else begin
            e = sb_q.pop_front();
            chk(e.is_bus && bus_cmd == e.cmd && bus_addr == e.addr &&
                (!e.cmp_data || bus_wdata == e.data), e.tag,
                {bus_cmd, bus_addr, 6'd0, bus_wdata}, {e.cmd, e.addr, 6'd0, e.data});
          end
          if (bus_cmd == 2'd1) bus_rdata = mem[bus_addr];
          else                 mem[bus_addr] = bus_wdata;
          bus_gnt = 1'b1;
          bus_ack = 1'b1;
          lat     = (lat == 3) ? 1 : lat + 1;
        end
      end
      if (cpu_done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "cpu", {16'd0, cpu_rdata}, 32'hFFFF_FFFF);
        end else begin
          e = sb_q.pop_front();
          chk(!e.is_bus && (!e.cmp_data || cpu_rdata == e.data), e.tag,
              {15'd0, e.is_bus, cpu_rdata}, {16'd0, e.data});
        end
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_addr  = addr;
    cpu_wdata = wd;
    do @(negedge clk); while (!cpu_done);
    cpu_req = 1'b0;
    @(negedge clk);
    chk(!cpu_done, "R13", {31'd0, cpu_done}, 32'd0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                       input logic exp_hold, input logic [31:0] tag);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_cmd   = cmd;
    snp_addr  = addr;
    @(negedge clk);
    chk(snp_hold == exp_hold, tag, {31'd0, snp_hold}, {31'd0, exp_hold});
    for (int i = 0; i < 40 && snp_hold; i++) @(negedge clk);
    chk(!snp_hold, tag, {31'd0, snp_hold}, 32'd0);
    snp_valid = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 8'h10, B = 8'h14, C = 8'h21, D = 8'h32;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'(i * 16'h0107) ^ 16'hA5C3;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 1'b0; bus_ack = 1'b0; bus_rdata = '0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!bus_req && !cpu_done && !snp_hold, "R1",
        {29'd0, bus_req, cpu_done, snp_hold}, 32'd0);

    // R1 R3: first read misses and fills
    exp_bus(2'd1, A, '0, "R3"); exp_cpu(1'b1, mem[A], "R3");
    cpu_op(1'b0, A, '0);
    // R2: read hit, no bus traffic
    exp_cpu(1'b1, mem[A], "R2");
    cpu_op(1'b0, A, '0);
    // R5: write to Valid writes through
    exp_bus(2'd2, A, 16'h1111, "R5"); exp_cpu(1'b0, '0, "R5");
    cpu_op(1'b1, A, 16'h1111);
    // R4: write to Reserved stays local
    exp_cpu(1'b0, '0, "R4");
    cpu_op(1'b1, A, 16'h2222);
    exp_cpu(1'b1, 16'h2222, "R4");
    cpu_op(1'b0, A, '0);
    // R7: dirty victim written back before the fill
    exp_bus(2'd3, A, 16'h2222, "R7"); exp_bus(2'd1, B, '0, "R7");
    exp_cpu(1'b1, mem[B], "R7");
    cpu_op(1'b0, B, '0);
    // R7: clean victim dropped silently
    exp_bus(2'd1, A, '0, "R7"); exp_cpu(1'b1, 16'h2222, "R7");
    cpu_op(1'b0, A, '0);
    // R6: write miss = fill then write-through
    exp_bus(2'd1, C, '0, "R6"); exp_bus(2'd2, C, 16'h3333, "R6");
    exp_cpu(1'b0, '0, "R6");
    cpu_op(1'b1, C, 16'h3333);
    // R9: snooped read of Reserved -> Valid, next write goes through
    snoop(2'd1, C, 1'b0, "R9");
    exp_bus(2'd2, C, 16'h4444, "R9"); exp_cpu(1'b0, '0, "R9");
    cpu_op(1'b1, C, 16'h4444);
    exp_cpu(1'b0, '0, "R4");
    cpu_op(1'b1, C, 16'h5555);
    // R8: snooped read of Dirty -> hold, write-back, Valid
    exp_bus(2'd3, C, 16'h5555, "R8");
    snoop(2'd1, C, 1'b1, "R8");
    chk(mem[C] == 16'h5555, "R8", {16'd0, mem[C]}, 32'h5555);
    exp_cpu(1'b1, 16'h5555, "R8");
    cpu_op(1'b0, C, '0);
    exp_bus(2'd2, C, 16'h6666, "R8"); exp_cpu(1'b0, '0, "R8");
    cpu_op(1'b1, C, 16'h6666);
    // R10: snooped write-through invalidates
    snoop(2'd2, A, 1'b0, "R10");
    mem[A] = 16'h7777;
    exp_bus(2'd1, A, '0, "R10"); exp_cpu(1'b1, 16'h7777, "R10");
    cpu_op(1'b0, A, '0);

    // R11: snoop and request together; request waits
    exp_bus(2'd1, D, '0, "R11"); exp_cpu(1'b1, mem[D], "R11");
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h33;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = D;
    @(negedge clk);
    chk(!cpu_done && !bus_req, "R11", {30'd0, cpu_done, bus_req}, 32'd0);
    snp_valid = 1'b0;
    for (int i = 0; i < 40 && !cpu_done; i++) @(negedge clk);
    cpu_req = 1'b0;
    @(negedge clk);
    chk(!cpu_done, "R13", {31'd0, cpu_done}, 32'd0);

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2", sb_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL all watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule